// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is one channel of a general-purpose timer. It contains a free-running up-counter that wraps at a programmable modulo value. The channel uses that counter in one of three ways. It can record the counter value when an edge arrives on an input pin. It can drive an output pin when the counter reaches a programmed value. It can also produce a pulse-width-modulated waveform by pairing a compare action with a toggle on every counter wrap.

Software reaches the channel through a simple word-wide register port. The port has five registers: control, two value registers, modulo and a read-only count. The control register holds a sticky event flag, an interrupt enable, two mode bits, two edge/level bits, a toggle-on-wrap bit and a full-duty bit. The flag clears only through a read-then-write sequence. In buffered mode the two value registers take turns as the active compare value, switching at each wrap. A new duty value written to the idle register therefore takes effect at a period boundary.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the control register, both value registers, `cmp_out` and `irq` read 0, and the modulo register (address 3) reads all ones.
- R2: The counter steps by one per clock from 0 up to the modulo value and then returns to 0. Writing the modulo register restarts the counter at 0. The count is readable at address 4.
- R3: When control bits [5:2] are all zero, the channel is idle: pin edges set no flag and `cmp_out` stays 0.
- R4: With mode bits [5:4] = 00, the edge bits [3:2] select the capture trigger: 01 rising edge, 10 falling edge, 11 either edge. A non-selected edge sets no flag.
- R5: On an active capture edge, the counter value is stored into value register A (address 1). The input is synchronised through two flops before edge detection.
- R6: In compare mode (bit 5 or bit 4 set), the flag (control bit 7) sets when the counter equals the active value register.
- R7: In compare mode, bits [3:2] choose the pin action on a match: 01 toggle, 10 drive low, 11 drive high. `cmp_out` is held low in every non-compare mode.
- R8: The flag clears only when control is written with bit 7 = 0 after a read of control that saw the flag set, with no control write in between. Writing bit 7 = 1 never sets or clears it, and a new event wins over a same-cycle clear.
- R9: `irq` is high exactly when the flag and the interrupt enable (control bit 6) are both set.
- R10: With control bit 1 set, `cmp_out` toggles at each counter wrap. With modulo M, value V and drive-low action, the output is high for V+1 of every M+1 cycles. When a match and a wrap fall on the same cycle, the match action alone applies.
- R11: With control bit 0 set in compare mode, `cmp_out` is forced high from the next wrap on and matches no longer move it. Clearing the bit returns normal PWM.
- R12: With bit 5 set (buffered), the active compare register alternates between A and B at every wrap. A write to the inactive register does not move the current period.
- R13: With bit 4 set alone (unbuffered), register A is always the compare value, and a write to it is used from the next match on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | 3 | Register address: 0 control, 1 value A, 2 value B, 3 modulo, 4 count |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| cap_in | input | 1 | Capture input pin, asynchronous |
| cmp_out | output | 1 | Registered compare/PWM output pin |
| irq | output | 1 | Channel interrupt request |

## Verification
The hardest situation to reach is the two-step flag clear, because the read that arms the clear is also the only way to observe the flag. Any check of the flag can therefore enable the clear it is meant to test. The stimulus uses a long modulo period so the flag stays set for a known stretch. Control writes with bit 7 = 0 are then issued both before any read and after one, and a readback follows each write. The buffered alternation is reached by measuring consecutive high runs of the PWM output and comparing them against the two programmed values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_VAL_A = 3'd1;
  localparam logic [REG_AW-1:0] A_VAL_B = 3'd2;
  localparam logic [REG_AW-1:0] A_MOD   = 3'd3;
  localparam logic [REG_AW-1:0] A_CNT   = 3'd4;

  localparam int FLAG_BIT = 7;
  localparam int CTRL_W   = 8;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } pin_act_e;

  // control bits 6..0; bit 7 (flag) is held separately
  typedef struct packed {
    logic irq_en;
    logic buf_mode;
    logic cmp_mode;
    logic lvl_hi;
    logic lvl_lo;
    logic ovf_tog;
    logic full_duty;
  } cfg_t;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int              W        = 16,
  parameter logic [W-1:0]    MOD_INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mod_wr,
  input  logic [W-1:0] mod_wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] modulo,
  output logic         ovf
);
  localparam logic [W-1:0] ONE = W'(1);

  assign ovf = (cnt == modulo);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      modulo <= MOD_INIT;
    end else if (mod_wr) begin
      modulo <= mod_wdata;
      cnt    <= '0;
    end else begin
      cnt <= ovf ? '0 : cnt + ONE;
    end
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr_pin_drive.sv
module tmr_pin_drive
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  pin_act_e act,
  input  logic     tog_en,
  input  logic     full,
  input  logic     ovf,
  input  logic     match,
  output logic     pin
);
  logic hold_q;
  logic force_hi;

  assign force_hi = full && (hold_q || ovf);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pin    <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= force_hi;
      if (force_hi) begin
        pin <= 1'b1;
      end else if (match && act != ACT_NONE) begin
        case (act)
          ACT_TOGGLE: pin <= ~pin;
          ACT_CLEAR:  pin <= 1'b0;
          default:    pin <= 1'b1;
        endcase
      end else if (ovf && tog_en) begin
        pin <= ~pin;
      end
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] MOD_INIT    = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic              cmp_out,
  output logic              irq
);
  localparam int NUM_VAL = 2;

  cfg_t             cfg_q;
  logic             flag_q;
  logic             arm_q;
  logic             sel_q;
  logic [CNT_W-1:0] val_q [NUM_VAL];
  logic [CNT_W-1:0] val_a;
  logic [CNT_W-1:0] act_val;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] modulo;
  logic             ovf;
  logic             rise, fall;
  logic             wr_ctrl, rd_ctrl, wr_mod;
  logic             oc_mode, ic_mode;
  logic             cmp_hit, ic_hit, flag_evt;
  logic [CNT_W-1:0] rd_mux;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign rd_ctrl = bus_rd && (bus_addr == A_CTRL);
  assign wr_mod  = bus_wr && (bus_addr == A_MOD);

  tmr_count #(.W(CNT_W), .MOD_INIT(MOD_INIT)) i_count (
    .clk       (clk),
    .rst       (rst),
    .mod_wr    (wr_mod),
    .mod_wdata (bus_wdata),
    .cnt       (cnt),
    .modulo    (modulo),
    .ovf       (ovf)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (cap_in),
    .rise (rise),
    .fall (fall)
  );

  // mode decode
  assign oc_mode = cfg_q.buf_mode || cfg_q.cmp_mode;
  assign ic_mode = !oc_mode && (cfg_q.lvl_hi || cfg_q.lvl_lo);

  assign act_val  = sel_q ? val_q[1] : val_q[0];
  assign val_a    = val_q[0];
  assign cmp_hit  = oc_mode && (cnt == act_val);
  assign ic_hit   = ic_mode && ((cfg_q.lvl_lo && rise) || (cfg_q.lvl_hi && fall));
  assign flag_evt = cmp_hit || ic_hit;

  tmr_pin_drive i_pin (
    .clk    (clk),
    .rst    (rst),
    .en     (oc_mode),
    .act    (pin_act_e'({cfg_q.lvl_hi, cfg_q.lvl_lo})),
    .tog_en (cfg_q.ovf_tog),
    .full   (cfg_q.full_duty),
    .ovf    (ovf),
    .match  (cmp_hit),
    .pin    (cmp_out)
  );

  // control register and sticky flag
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (wr_ctrl) cfg_q <= cfg_t'(bus_wdata[CTRL_W-2:0]);
      if (flag_evt)
        flag_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[FLAG_BIT] && arm_q)
        flag_q <= 1'b0;
      if (wr_ctrl)
        arm_q <= 1'b0;
      else if (rd_ctrl && flag_q)
        arm_q <= 1'b1;
    end
  end

  // value register pair; entry 0 also takes captures
  for (genvar g = 0; g < NUM_VAL; g++) begin : g_val
    localparam logic [REG_AW-1:0] MY_ADDR = A_VAL_A + REG_AW'(g);
    always_ff @(posedge clk) begin
      if (rst)
        val_q[g] <= '0;
      else if (g == 0 && ic_hit)
        val_q[g] <= cnt;
      else if (bus_wr && bus_addr == MY_ADDR)
        val_q[g] <= bus_wdata;
    end
  end

  // buffered alternation
  always_ff @(posedge clk) begin
    if (rst || !cfg_q.buf_mode)
      sel_q <= 1'b0;
    else if (ovf)
      sel_q <= ~sel_q;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  rd_mux = CNT_W'({flag_q, cfg_q});
      A_VAL_A: rd_mux = val_q[0];
      A_VAL_B: rd_mux = val_q[1];
      A_MOD:   rd_mux = modulo;
      A_CNT:   rd_mux = cnt;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  assign irq = flag_q && cfg_q.irq_en;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt,
  input logic              ovf,
  input logic              wr_mod,
  input logic              oc_mode,
  input logic              buf_mode,
  input logic              full,
  input logic              sel_q,
  input logic              cmp_hit,
  input logic              ic_hit,
  input logic              flag_q,
  input logic [CNT_W-1:0]  val_a,
  input logic              pin,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata
);
  a_r2_counter_wrap: assert property (@(posedge clk) disable iff (rst)
    (ovf && !wr_mod) |=> (cnt == '0));

  a_r3_idle_pin_low: assert property (@(posedge clk) disable iff (rst)
    !oc_mode |=> !pin);

  a_r5_capture_value: assert property (@(posedge clk) disable iff (rst)
    ic_hit |=> (val_a == $past(cnt)));

  a_r6_flag_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(cmp_hit || ic_hit));

  a_r8_flag_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(bus_wr && bus_addr == A_CTRL && !bus_wdata[FLAG_BIT]));

  a_r11_full_duty_high: assert property (@(posedge clk) disable iff (rst)
    (oc_mode && full && ovf && !(bus_wr && bus_addr == A_CTRL)) |=> pin);

  a_r12_buffer_swap: assert property (@(posedge clk) disable iff (rst)
    (buf_mode && ovf) |=> (sel_q != $past(sel_q)));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt       (cnt),
  .ovf       (ovf),
  .wr_mod    (wr_mod),
  .oc_mode   (oc_mode),
  .buf_mode  (cfg_q.buf_mode),
  .full      (cfg_q.full_duty),
  .sel_q     (sel_q),
  .cmp_hit   (cmp_hit),
  .ic_hit    (ic_hit),
  .flag_q    (flag_q),
  .val_a     (val_a),
  .pin       (cmp_out),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/test_tmr_chan.sv
module test_tmr_chan;
  import tmr_pkg::*;
  localparam int W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [REG_AW-1:0] bus_addr = '0;
  logic [W-1:0]      bus_wdata = '0;
  logic [W-1:0]      bus_rdata;
  logic              cap_in = 1'b0;
  logic              cmp_out;
  logic              irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tmr_chan #(.CNT_W(W)) i_tmr_chan (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_in    (cap_in),
    .cmp_out   (cmp_out),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [REG_AW-1:0] a, input logic [W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [W-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_count(input int n, output int h);
    h = 0;
    repeat (n) begin
      if (cmp_out) h++;
      @(negedge clk);
    end
  endtask

  task automatic high_run(output int n);
    while (cmp_out !== 1'b0) @(negedge clk);
    while (cmp_out !== 1'b1) @(negedge clk);
    n = 0;
    while (cmp_out === 1'b1) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clear_flag(input logic [W-1:0] cfg);
    logic [W-1:0] d;
    rd(A_CTRL, d);
    wr(A_CTRL, cfg & 16'h007F);
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    check("R1 cmp_out", W'(cmp_out), 0);
    check("R1 irq", W'(irq), 0);
    rd(A_CTRL, d);  check("R1 ctrl", d, 0);
    rd(A_VAL_A, d); check("R1 value A", d, 0);
    rd(A_VAL_B, d); check("R1 value B", d, 0);
    rd(A_MOD, d);   check("R1 modulo", d, 16'hFFFF);
  endtask

  task automatic t_counter;
    logic [W-1:0] r [12];
    wr(A_MOD, 16'd9);
    for (int i = 0; i < 12; i++) rd(A_CNT, r[i]);
    check("R2 restart", r[0], 0);
    check("R2 step", r[5], 5);
    check("R2 top", r[9], 9);
    check("R2 wrap", r[10], 0);
  endtask

  task automatic t_flag;
    logic [W-1:0] d;
    wr(A_MOD, 16'd999);
    wr(A_VAL_A, 16'd10);
    wr(A_CTRL, 16'h0010);
    idle(20);
    rd(A_CTRL, d);      check("R6 flag on match", d, 16'h0090);
    check("R9 irq masked", W'(irq), 0);
    wr(A_CTRL, 16'h0010);
    rd(A_CTRL, d);      check("R8 read+write0 clears", d, 16'h0010);
    idle(1000);
    wr(A_CTRL, 16'h0010);
    rd(A_CTRL, d);      check("R8 write0 without read keeps", d, 16'h0090);
    wr(A_CTRL, 16'h00D0);
    rd(A_CTRL, d);      check("R8 write1 keeps", d, 16'h00D0);
    check("R9 irq on", W'(irq), 1);
    wr(A_CTRL, 16'h0050);
    check("R9 irq off", W'(irq), 0);
    wr(A_CTRL, 16'h00D0);
    rd(A_CTRL, d);      check("R8 write1 does not set", d, 16'h0050);
  endtask

  task automatic t_capture;
    logic [W-1:0] d, c0, c1, v;
    wr(A_MOD, 16'hFFFF);
    wr(A_CTRL, 16'h0004);
    idle(5);
    rd(A_CNT, c0);
    cap_in = 1'b1;
    idle(6);
    rd(A_CNT, c1);
    rd(A_CTRL, d);      check("R4 rising sets flag", d, 16'h0084);
    rd(A_VAL_A, v);
    check("R5 captured count in window", W'(v > c0 && v < c1), 1);
    clear_flag(16'h0004);
    cap_in = 1'b0; idle(6);
    rd(A_CTRL, d);      check("R4 falling ignored in rising mode", d, 16'h0004);
    wr(A_CTRL, 16'h0008);
    cap_in = 1'b1; idle(6);
    rd(A_CTRL, d);      check("R4 rising ignored in falling mode", d, 16'h0008);
    cap_in = 1'b0; idle(6);
    rd(A_CTRL, d);      check("R4 falling sets flag", d, 16'h0088);
    clear_flag(16'h000C);
    cap_in = 1'b1; idle(6);
    rd(A_CTRL, d);      check("R4 any edge rise", d, 16'h008C);
    clear_flag(16'h000C);
    cap_in = 1'b0; idle(6);
    rd(A_CTRL, d);      check("R4 any edge fall", d, 16'h008C);
  endtask

  task automatic t_idle;
    logic [W-1:0] d;
    clear_flag(16'h0000);
    cap_in = 1'b1; idle(6);
    cap_in = 1'b0; idle(6);
    rd(A_CTRL, d);      check("R3 idle no flag", d, 0);
    check("R3 idle pin low", W'(cmp_out), 0);
  endtask

  task automatic t_actions;
    int h;
    wr(A_MOD, 16'd19);
    wr(A_VAL_A, 16'd5);
    wr(A_CTRL, 16'h001C);
    idle(25);           check("R7 set action", W'(cmp_out), 1);
    wr(A_CTRL, 16'h0018);
    idle(25);           check("R7 clear action", W'(cmp_out), 0);
    wr(A_CTRL, 16'h0014);
    idle(25);
    high_count(40, h);  check("R7 toggle action", W'(h), 20);
  endtask

  task automatic t_pwm;
    int h;
    wr(A_MOD, 16'd19);
    wr(A_VAL_A, 16'd7);
    wr(A_CTRL, 16'h001A);
    idle(45);
    high_count(20, h);  check("R10 pwm duty", W'(h), 8);
    wr(A_VAL_A, 16'd12);
    idle(25);
    high_count(20, h);  check("R13 unbuffered update", W'(h), 13);
    wr(A_VAL_A, 16'd19);
    idle(45);
    high_count(20, h);  check("R10 match beats wrap", W'(h), 0);
    wr(A_VAL_A, 16'd7);
    wr(A_CTRL, 16'h001B);
    idle(45);
    high_count(20, h);  check("R11 forced full duty", W'(h), 20);
    wr(A_CTRL, 16'h001A);
    idle(45);
    high_count(20, h);  check("R11 back to pwm", W'(h), 8);
  endtask

  task automatic t_buffered;
    int r1, r2;
    wr(A_MOD, 16'd19);
    wr(A_VAL_A, 16'd3);
    wr(A_VAL_B, 16'd11);
    wr(A_CTRL, 16'h002A);
    idle(45);
    high_run(r1);
    high_run(r2);
    check("R12 alternating sum", W'(r1 + r2), 16);
    check("R12 alternating runs", W'((r1 == 4 || r1 == 12) && r1 != r2), 1);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_counter();
    t_flag();
    t_capture();
    t_idle();
    t_actions();
    t_pwm();
    t_buffered();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end
endmodule